// File: doc/BRIEF.md
# Parallel Address Range Classifier

This block sits on the request path of a shared memory and labels each request before a downstream policy checker decides whether it is legal. A request carries the ID of the issuing on-chip module, a two-bit operation field and a byte address. The block compares that address against every configured range entry in the same cycle. It emits an access descriptor one clock later. The descriptor holds the module ID, the operation and one hit bit per range entry.

Each range entry is a ternary pattern made of a value word, a mask word and an enable bit. A mask bit of 1 marks that address bit as don't-care. Because entries may overlap (a small control-word window inside a larger peripheral window, for instance), the hit vector is multi-hot. A separate flag reports addresses that fall in no enabled range. Entries are loaded through a simple index/field/data configuration port.

Top module: `range_classifier`

## Requirements
- R1: The descriptor carries the module ID and operation bits of its request unchanged; operation bit 0 means read and bit 1 means write.
- R2: Hit bit i is 1 exactly when entry i is enabled and the address equals the entry value on every bit whose mask bit is 0; a mask bit of 1 is don't-care.
- R3: When an address lies inside several enabled entries, every one of their hit bits is set in the same descriptor.
- R4: Value bits at positions whose mask bit is 1 have no effect on the result.
- R5: A disabled entry never hits; when no entry hits, the hit vector is all zero and desc_miss is 1, otherwise desc_miss is 0.
- R6: A descriptor appears with desc_valid high one cycle after each accepted request, requests may arrive on every cycle, and desc_valid is low in the cycle after a cycle with no request.
- R7: A configuration write with cfg_field 0 loads the value word, 1 loads the mask word, 2 loads the enable bit from cfg_data bit 0, and 3 changes nothing. The write affects requests from the next cycle on; a request in the same cycle as the write is classified with the old contents.
- R8: A configuration write whose cfg_index is not below the number of entries changes no entry.
- R9: After reset every entry is disabled with zero value and mask, and desc_valid is 0.
- R10: While no request arrives, the descriptor fields keep the values of the last descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_module | input | MOD_W | ID of the requesting module |
| req_op | input | 2 | Operation: bit 0 read, bit 1 write |
| req_addr | input | ADDR_W | Request byte address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | 0 value, 1 mask, 2 enable, 3 no effect |
| cfg_index | input | IDX_W | Entry number to write |
| cfg_data | input | ADDR_W | Write data |
| desc_valid | output | 1 | Descriptor is valid this cycle |
| desc_module | output | MOD_W | Module ID of the classified request |
| desc_op | output | 2 | Operation of the classified request |
| desc_hits | output | N_RANGES | One hit bit per range entry |
| desc_miss | output | 1 | No enabled entry matched |

## Verification
The hardest case to reach from the ports is a configuration write and a request in the same clock cycle. The request must still see the old entry contents, while the request in the next cycle must see the new ones. The bench drives both strobes in one cycle, enabling an entry that would otherwise catch the address, and then repeats the request. Stray value bits under don't-care positions, and overlapping windows whose hit bits must both rise, are set up in the same way from the configuration port.

// File: rtl/range_match_pkg.sv
// Shared definitions for the range classifier.
// Assumes nothing beyond a two-bit field selector on the configuration port.
package range_match_pkg;

    // Field selected by a configuration write
    typedef enum logic [1:0] {
        CFG_VALUE  = 2'd0,
        CFG_MASK   = 2'd1,
        CFG_ENABLE = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_field_e;

    // Bit positions inside the operation field
    localparam int OP_READ_BIT  = 0;
    localparam int OP_WRITE_BIT = 1;
    localparam int OP_W         = 2;

endpackage

// File: rtl/range_entry.sv
// One ternary range entry: holds a value word, a mask word (1 = don't-care)
// and an enable bit, and compares a lookup address against them in one step.
// Assumes MY_IDX is below 2**IDX_W; indices that select no entry are ignored.
module range_entry
    import range_match_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int MY_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  cfg_field_e        cfg_field,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              hit
);

    logic [ADDR_W-1:0] val_q;
    logic [ADDR_W-1:0] msk_q;
    logic              en_q;
    logic              sel_me;
    logic [ADDR_W-1:0] diff_cared;

    // Decode whether the current configuration write targets this entry
    assign sel_me = cfg_we && (cfg_index == IDX_W'(MY_IDX));

    // Load the selected field of this entry on a matching configuration write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            msk_q <= '0;
            en_q  <= 1'b0;
        end else if (sel_me) begin
            case (cfg_field)
                CFG_VALUE:  val_q <= cfg_data;
                CFG_MASK:   msk_q <= cfg_data;
                CFG_ENABLE: en_q  <= cfg_data[0];
                default:    ;
            endcase
        end
    end

    // Ternary compare: only bits with a zero mask take part
    always_comb begin
        diff_cared = (lookup_addr ^ val_q) & ~msk_q;
        hit        = en_q && (diff_cared == '0);
    end

    AST_VALUE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_me && cfg_field == CFG_VALUE) |=> (val_q == $past(cfg_data))); // R7

    AST_FIELD_NONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_me && cfg_field == CFG_NONE) |=> ($stable(val_q) && $stable(msk_q) && $stable(en_q))); // R7

    AST_FULL_MASK_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && (&msk_q)) |-> hit); // R4

endmodule

// File: rtl/range_bank.sv
// Array of N range entries sharing one configuration port and one lookup
// address; returns the multi-hot hit vector combinationally.
// Assumes IDX_W is wide enough to address N entries.
module range_bank
    import range_match_pkg::*;
#(
    parameter int N_RANGES = 10,
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  cfg_field_e          cfg_field,
    input  logic [IDX_W-1:0]    cfg_index,
    input  logic [ADDR_W-1:0]   cfg_data,
    input  logic [ADDR_W-1:0]   lookup_addr,
    output logic [N_RANGES-1:0] hit_vec
);

    // One entry per range ID, all compared in parallel
    for (genvar g = 0; g < N_RANGES; g++) begin : g_entry
        range_entry #(
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W),
            .MY_IDX (g)
        ) i_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_we      (cfg_we),
            .cfg_field   (cfg_field),
            .cfg_index   (cfg_index),
            .cfg_data    (cfg_data),
            .lookup_addr (lookup_addr),
            .hit         (hit_vec[g])
        );
    end

endmodule

// File: rtl/desc_stage.sv
// Output register for the access descriptor. Captures module ID, operation,
// hit vector and no-match flag on each request and holds them otherwise.
// Assumes the hit vector is settled in the cycle the request is presented.
module desc_stage
    import range_match_pkg::*;
#(
    parameter int N_RANGES = 10,
    parameter int MOD_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [MOD_W-1:0]    in_module,
    input  logic [OP_W-1:0]     in_op,
    input  logic [N_RANGES-1:0] in_hits,
    output logic                out_valid,
    output logic [MOD_W-1:0]    out_module,
    output logic [OP_W-1:0]     out_op,
    output logic [N_RANGES-1:0] out_hits,
    output logic                out_miss
);

    // Valid strobe follows the request by exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Descriptor fields load on a request and hold while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_module <= '0;
            out_op     <= '0;
            out_hits   <= '0;
            out_miss   <= 1'b0;
        end else if (in_valid) begin
            out_module <= in_module;
            out_op     <= in_op;
            out_hits   <= in_hits;
            out_miss   <= ~|in_hits;
        end
    end

    AST_DESC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6

    AST_DESC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6

    AST_DESC_ID_OP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_module == $past(in_module) && out_op == $past(in_op))); // R1

    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_hits) && $stable(out_miss) && $stable(out_module))); // R10

endmodule

// File: rtl/range_classifier.sv
// Top of the parallel address range classifier. Each request address is
// checked against all range entries in the same cycle; the registered
// descriptor (module ID, operation, hit vector, no-match flag) follows one
// clock later. Assumes requests and configuration writes share one clock.
module range_classifier
    import range_match_pkg::*;
#(
    parameter  int N_RANGES = 10,
    parameter  int ADDR_W   = 32,
    parameter  int MOD_W    = 4,
    localparam int IDX_W    = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [MOD_W-1:0]    req_module,
    input  logic [1:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_field,
    input  logic [IDX_W-1:0]    cfg_index,
    input  logic [ADDR_W-1:0]   cfg_data,
    output logic                desc_valid,
    output logic [MOD_W-1:0]    desc_module,
    output logic [1:0]          desc_op,
    output logic [N_RANGES-1:0] desc_hits,
    output logic                desc_miss
);

    cfg_field_e          field_sel;
    logic [N_RANGES-1:0] hit_vec;

    // Interpret the raw field selector as the package enum
    assign field_sel = cfg_field_e'(cfg_field);

    range_bank #(
        .N_RANGES (N_RANGES),
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W)
    ) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_field   (field_sel),
        .cfg_index   (cfg_index),
        .cfg_data    (cfg_data),
        .lookup_addr (req_addr),
        .hit_vec     (hit_vec)
    );

    desc_stage #(
        .N_RANGES (N_RANGES),
        .MOD_W    (MOD_W)
    ) i_desc (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_module  (req_module),
        .in_op      (req_op),
        .in_hits    (hit_vec),
        .out_valid  (desc_valid),
        .out_module (desc_module),
        .out_op     (desc_op),
        .out_hits   (desc_hits),
        .out_miss   (desc_miss)
    );

    AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_miss) |-> (desc_hits == '0)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !desc_valid); // R9

endmodule

// File: tb/test_range_classifier.sv
// Directed bench for range_classifier: one task per scenario.
module test_range_classifier;

    localparam int CLK_PERIOD = 10;
    localparam int N      = 10;
    localparam int AW     = 32;
    localparam int MW     = 4;
    localparam int IW     = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [MW-1:0] req_module = '0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_field = '0;
    logic [IW-1:0] cfg_index = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          desc_valid;
    logic [MW-1:0] desc_module;
    logic [1:0]    desc_op;
    logic [N-1:0]  desc_hits;
    logic          desc_miss;

    int checks = 0;
    int errors = 0;

    // Bench model of the entry contents
    logic [AW-1:0] m_val [N];
    logic [AW-1:0] m_msk [N];
    logic          m_en  [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    range_classifier #(.N_RANGES(N), .ADDR_W(AW), .MOD_W(MW)) i_range_classifier (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_module(req_module), .req_op(req_op), .req_addr(req_addr),
        .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_index(cfg_index), .cfg_data(cfg_data),
        .desc_valid(desc_valid), .desc_module(desc_module), .desc_op(desc_op),
        .desc_hits(desc_hits), .desc_miss(desc_miss)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_hits(input logic [AW-1:0] a);
        logic [N-1:0] h;
        for (int i = 0; i < N; i++)
            h[i] = m_en[i] && (((a ^ m_val[i]) & ~m_msk[i]) == '0);
        return h;
    endfunction

    // One clock: rising edge, then back to a falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input int idx, input logic [1:0] fld, input logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_index = IW'(idx); cfg_field = fld; cfg_data = d;
        tick();
        cfg_we = 1'b0;
        if (idx < N) begin
            case (fld)
                2'd0: m_val[idx] = d;
                2'd1: m_msk[idx] = d;
                2'd2: m_en[idx]  = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic set_range(input int idx, input logic [AW-1:0] v, input logic [AW-1:0] m);
        cfg_write(idx, 2'd0, v);
        cfg_write(idx, 2'd1, m);
        cfg_write(idx, 2'd2, 32'd1);
    endtask

    task automatic check_desc(input string tag, input logic [MW-1:0] mod, input logic [1:0] op,
                              input logic [N-1:0] hits);
        check({tag, " valid"}, 64'(desc_valid), 64'(1));
        check({tag, " module"}, 64'(desc_module), 64'(mod));
        check({tag, " op"}, 64'(desc_op), 64'(op));
        check({tag, " hits"}, 64'(desc_hits), 64'(hits));
        check({tag, " miss"}, 64'(desc_miss), 64'(hits == '0));
    endtask

    // Single request, checked one cycle later
    task automatic request(input string tag, input logic [MW-1:0] mod, input logic [1:0] op,
                           input logic [AW-1:0] a);
        logic [N-1:0] exp_h;
        exp_h = model_hits(a);
        req_valid = 1'b1; req_module = mod; req_op = op; req_addr = a;
        tick();
        req_valid = 1'b0;
        check_desc(tag, mod, op, exp_h);
    endtask

    task automatic t_reset();
        check("R9 valid after reset", 64'(desc_valid), 64'(0));
        request("R9 R5 empty table", 4'd3, 2'b01, 32'h4060_0010);
        check("R5 empty table hits", 64'(desc_hits), 64'(0));
    endtask

    task automatic t_basic();
        set_range(0, 32'h4060_0000, 32'h0000_FFFF);
        set_range(1, 32'h2800_0000, 32'h0000_0FFF);
        set_range(2, 32'h2800_0004, 32'h0000_0003);
        request("R2 R1 periph read", 4'd1, 2'b01, 32'h4060_1234);
        check("R2 only entry0", 64'(desc_hits), 64'h1);
        request("R2 R1 write op", 4'd2, 2'b10, 32'h2800_0800);
        check("R2 only entry1", 64'(desc_hits), 64'h2);
        request("R2 bit outside", 4'd2, 2'b11, 32'h4061_0000);
    endtask

    task automatic t_overlap();
        request("R3 nested window", 4'd5, 2'b11, 32'h2800_0006);
        check("R3 two bits", 64'(desc_hits), 64'h6);
    endtask

    task automatic t_stray_value();
        set_range(3, 32'h2400_FFFF, 32'h0000_FFFF);
        request("R4 stray value bits", 4'd7, 2'b01, 32'h2400_1234);
        check("R4 entry3 hit", 64'(desc_hits[3]), 64'(1));
    endtask

    task automatic t_disable();
        cfg_write(0, 2'd2, 32'd0);
        request("R5 disabled entry", 4'd1, 2'b01, 32'h4060_1234);
        check("R5 miss flag", 64'(desc_miss), 64'(1));
        cfg_write(1, 2'd3, 32'hFFFF_FFFF);
        request("R7 field 3 no effect", 4'd1, 2'b01, 32'h2800_0800);
    endtask

    task automatic t_bad_index();
        cfg_write(10, 2'd1, 32'hFFFF_FFFF);
        cfg_write(10, 2'd2, 32'd1);
        cfg_write(15, 2'd1, 32'hFFFF_FFFF);
        cfg_write(15, 2'd2, 32'd1);
        request("R8 index beyond table", 4'd4, 2'b01, 32'h1357_9BDF);
        check("R8 no hit", 64'(desc_hits), 64'(0));
    endtask

    task automatic t_same_cycle();
        logic [N-1:0] old_h;
        old_h = model_hits(32'h7777_0000);
        set_range(5, 32'h0000_0000, 32'hFFFF_FFFF);
        cfg_write(5, 2'd2, 32'd0);
        // enable entry 5 and request in the same cycle
        cfg_we = 1'b1; cfg_index = 4'd5; cfg_field = 2'd2; cfg_data = 32'd1;
        req_valid = 1'b1; req_module = 4'd9; req_op = 2'b10; req_addr = 32'h7777_0000;
        tick();
        cfg_we = 1'b0; req_valid = 1'b0;
        m_en[5] = 1'b1;
        check_desc("R7 same cycle old contents", 4'd9, 2'b10, old_h);
        request("R7 next cycle new contents", 4'd9, 2'b10, 32'h7777_0000);
        check("R7 entry5 now hits", 64'(desc_hits[5]), 64'(1));
        cfg_write(5, 2'd2, 32'd0);
    endtask

    task automatic t_back_to_back();
        logic [N-1:0] h1, h2, h3;
        h1 = model_hits(32'h2800_0005);
        h2 = model_hits(32'h2400_0000);
        h3 = model_hits(32'h0000_0000);
        req_valid = 1'b1; req_module = 4'd1; req_op = 2'b01; req_addr = 32'h2800_0005;
        tick();
        req_module = 4'd2; req_op = 2'b10; req_addr = 32'h2400_0000;
        check_desc("R6 burst first", 4'd1, 2'b01, h1);
        tick();
        req_module = 4'd3; req_op = 2'b11; req_addr = 32'h0000_0000;
        check_desc("R6 burst second", 4'd2, 2'b10, h2);
        tick();
        req_valid = 1'b0;
        check_desc("R6 burst third", 4'd3, 2'b11, h3);
        tick();
        check("R6 idle valid low", 64'(desc_valid), 64'(0));
        check("R10 hits held", 64'(desc_hits), 64'(h3));
        check("R10 module held", 64'(desc_module), 64'(3));
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_val[i] = '0; m_msk[i] = '0; m_en[i] = 1'b0;
        end
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_overlap();
        t_stray_value();
        t_disable();
        t_bad_index();
        t_same_cycle();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule